// File: doc/BRIEF.md
# PWM Phase Alignment Controller

This block is the shared timing hub for a bank of PWM channels. It owns one free-running offset counter that all channels compare against their programmed offsets. It also owns a one-cycle alignment strobe that tells every channel to restart its period in step. The strobe is raised when a falling edge is seen on either of two inputs. One is a software-driven configuration-load line. The other is an external sync pin. In the same cycle as the strobe, the offset counter is cleared to zero. After that it counts up by one per clock and holds at its top value, so no offset is passed a second time.

Four runtime flags live in a small control word that software can overwrite. Each flag takes a build-time default on reset.
- The hold flag keeps the channel bank stopped after a system reset until software clears it.
- The external-align flag selects how the external sync is used. When set, every falling edge of the sync pin realigns the channels. When clear, a falling edge of the load line must first arm the controller while the sync pin is high. The next falling edge of the sync pin then fires the strobe, and the arm is used up.
- The force-align and start-at-sync flags pass through to the channels.

When the sync pin is declared asynchronous, it goes through a two-flop synchronizer before edge detection.

Top module: `pwm_align_ctrl`

## Requirements
- R1: After a synchronous reset the control word holds its defaults. With the default parameters these are hold=1, external-align=0, force-align=0 and start-at-sync=1. Also `chan_run`=0, `offs_cnt`=0 and `align_o`=0.
- R2: While the hold flag (control bit 0) is 1, `chan_run` is 0, `offs_cnt` stays 0, and no falling edge on either input produces an alignment strobe or arms the controller. Once a write clears the flag, `chan_run` is 1 in the same sample, and the counter reads 1 one cycle later.
- R3: With external-align (control bit 1) set, every falling edge of `ext_sync` yields a strobe. The strobe appears 2 clock edges after the edge when `ASYNC_SYNC`=0, and 4 edges after it when `ASYNC_SYNC`=1.
- R4: With external-align clear and the controller not armed, a falling edge of `ext_sync` produces no strobe, and the counter keeps incrementing.
- R5: With external-align clear, a falling edge of `load_cfg` while `ext_sync` is high arms the controller without a strobe. The next falling edge of `ext_sync` fires a strobe. A further `ext_sync` falling edge without a new arm fires nothing.
- R6: A falling edge of `load_cfg` that does not arm fires a strobe 2 edges later. This covers the case where `ext_sync` is low in armed mode, and any `load_cfg` falling edge in external-align mode.
- R7: In the cycle the strobe is high, `offs_cnt` reads 0. Each following cycle it is one higher.
- R8: `offs_cnt` stops at 2^CNT_W-1 and stays there until the next strobe.
- R9: The strobe lasts exactly one cycle for a single edge, and all N_CH bits of `align_o` are always equal.
- R10: A write replaces the control word. Bit 2 appears on `force_align_o` and bit 3 on `start_at_sync_o` in the sample after the write edge.
- R11: With `ASYNC_SYNC`=1, `ext_sync` passes through two synchronizer flops, so the strobe comes 2 cycles later than with `ASYNC_SYNC`=0. `load_cfg` latency is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | New control word: bit0 hold, bit1 external-align, bit2 force-align, bit3 start-at-sync |
| load_cfg | input | 1 | Software configuration-load line, falling edge is the event |
| ext_sync | input | 1 | External sync pin, falling edge is the event |
| offs_cnt | output | CNT_W | Shared saturating offset counter |
| align_o | output | N_CH | One-cycle alignment strobe, one copy per channel |
| chan_run | output | 1 | High when the channel bank may run (hold flag clear) |
| force_align_o | output | 1 | Force-align flag to the channels |
| start_at_sync_o | output | 1 | Start-at-sync flag to the channels |

## Verification
The hardest state to reach is the armed mode sequence. The controller must be armed by a load-line edge while the sync pin is high. The stimulus must then show that the arm is consumed by exactly one sync edge. The stimulus first releases the hold flag. It then raises the sync pin and waits for it to settle through every synchronizer stage. Next it pulses the load line, checks that no strobe appears, and drops the sync pin. Finally it raises and drops the sync pin again to prove that the second edge is ignored. A second instance with the synchronizer enabled gets the same inputs, so the two-cycle latency difference is checked edge for edge.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;

  // Runtime control word. Bit 0 is hold, bit 1 external-align,
  // bit 2 force-align, bit 3 start-at-sync.
  typedef struct packed {
    logic start_at_sync;
    logic force_align;
    logic ext_align;
    logic hold;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic ctl_t ctl_default(input bit hold_d, input bit ext_d,
                                       input bit force_d, input bit start_d);
    ctl_t c;
    c.hold          = hold_d;
    c.ext_align     = ext_d;
    c.force_align   = force_d;
    c.start_at_sync = start_d;
    return c;
  endfunction

endpackage

// File: rtl/pwm_fall_detect.sv
// Input conditioning and falling-edge detection for one control line.
// STAGES extra flops are placed in front when the line is asynchronous.
module pwm_fall_detect #(
  parameter int STAGES = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rst_val,
  output logic level,
  output logic fall
);

  logic cond;

  generate
    if (STAGES > 0) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{rst_val}};
        else     chain <= {chain[STAGES-2:0], din};
      end
      assign cond = chain[STAGES-1];
    end else begin : g_direct
      assign cond = din;
    end
  endgenerate

  logic cur_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= rst_val;
      prev_q <= rst_val;
    end else begin
      cur_q  <= cond;
      prev_q <= cur_q;
    end
  end

  assign level = cur_q;
  assign fall  = prev_q & ~cur_q;

endmodule

// File: rtl/pwm_align_trig.sv
// Decides when an alignment fires and keeps the armed state.
module pwm_align_trig (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ext_align,
  input  logic ext_level,
  input  logic ext_fall,
  input  logic load_fall,
  output logic trig
);

  logic armed_q;
  logic arm_now;

  always_comb begin
    arm_now = 1'b0;
    trig    = 1'b0;
    if (!hold) begin
      if (ext_align) begin
        trig = ext_fall | load_fall;
      end else begin
        arm_now = load_fall & ext_level;
        trig    = (ext_fall & armed_q) | (load_fall & ~ext_level);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    armed_q <= 1'b0;
    else if (hold || ext_align) armed_q <= 1'b0;
    else if (arm_now)           armed_q <= 1'b1;
    else if (trig)              armed_q <= 1'b0;
  end

  // R5: a fired alignment consumes the arm
  a_r5_arm_used: assert property (@(posedge clk) disable iff (rst)
    trig |=> !armed_q);

  // R2: holding never leaves the controller armed
  a_r2_hold_disarms: assert property (@(posedge clk) disable iff (rst)
    hold |=> !armed_q);

  // R4: an unarmed sync edge in armed mode never fires
  a_r4_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    (!ext_align && !armed_q && !load_fall) |-> !trig);

endmodule

// File: rtl/pwm_offset_cnt.sv
// Shared offset counter: cleared on request, then saturating increment.
module pwm_offset_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // R7: cleared in the cycle after a request
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R7: steady increment below the top
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  // R8: holds at the top
  a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/pwm_align_ctrl.sv
module pwm_align_ctrl
  import pwm_align_pkg::*;
#(
  parameter int N_CH          = 16,
  parameter int CNT_W         = 32,
  parameter bit ASYNC_SYNC    = 1'b0,
  parameter bit DEF_HOLD      = 1'b1,
  parameter bit DEF_EXT_ALIGN = 1'b0,
  parameter bit DEF_FORCE     = 1'b0,
  parameter bit DEF_START     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  input  logic             load_cfg,
  input  logic             ext_sync,
  output logic [CNT_W-1:0] offs_cnt,
  output logic [N_CH-1:0]  align_o,
  output logic             chan_run,
  output logic             force_align_o,
  output logic             start_at_sync_o
);

  localparam int   SYNC_STAGES = ASYNC_SYNC ? 2 : 0;
  localparam ctl_t CTL_RST     = ctl_default(DEF_HOLD, DEF_EXT_ALIGN, DEF_FORCE, DEF_START);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= CTL_RST;
    else if (cfg_we) ctl_q <= ctl_t'(cfg_wdata);
  end

  assign chan_run        = ~ctl_q.hold;
  assign force_align_o   = ctl_q.force_align;
  assign start_at_sync_o = ctl_q.start_at_sync;

  logic ext_level, ext_fall, load_level, load_fall;

  pwm_fall_detect #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .din(ext_sync), .rst_val(1'b0),
    .level(ext_level), .fall(ext_fall)
  );

  pwm_fall_detect #(.STAGES(0)) u_load (
    .clk(clk), .rst(rst), .din(load_cfg), .rst_val(1'b0),
    .level(load_level), .fall(load_fall)
  );

  logic trig;

  pwm_align_trig u_trig (
    .clk(clk), .rst(rst), .hold(ctl_q.hold), .ext_align(ctl_q.ext_align),
    .ext_level(ext_level), .ext_fall(ext_fall), .load_fall(load_fall),
    .trig(trig)
  );

  pwm_offset_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(trig | ctl_q.hold), .cnt(offs_cnt)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_bcast
      always_ff @(posedge clk) begin
        if (rst) align_o[i] <= 1'b0;
        else     align_o[i] <= trig;
      end
    end
  endgenerate

  // R9: every channel sees the same strobe
  a_r9_bcast: assert property (@(posedge clk) disable iff (rst)
    ($countones(align_o) == 0) || ($countones(align_o) == N_CH));

  // R7: strobe and cleared counter coincide
  a_r7_strobe_zero: assert property (@(posedge clk) disable iff (rst)
    align_o[0] |-> (offs_cnt == '0));

  // R2: a held bank keeps the counter at zero and stays silent
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(ctl_q.hold) && ctl_q.hold) |-> (offs_cnt == '0 && align_o == '0));

  // R10: the flag outputs follow a write
  a_r10_write: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (force_align_o == $past(cfg_wdata[2]) &&
                start_at_sync_o == $past(cfg_wdata[3])));

endmodule

// File: tb/sim_pwm_align_ctrl.sv
module sim_pwm_align_ctrl;

  localparam int N_CH  = 4;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'd0;
  logic load_cfg = 1'b0;
  logic ext_sync = 1'b0;

  logic [CNT_W-1:0] cnt0, cnt1;
  logic [N_CH-1:0]  al0, al1;
  logic run0, run1, frc0, frc1, sas0, sas1;

  always #2 clk = ~clk;  // 250 MHz

  pwm_align_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W), .ASYNC_SYNC(1'b0)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .load_cfg(load_cfg), .ext_sync(ext_sync), .offs_cnt(cnt0),
    .align_o(al0), .chan_run(run0), .force_align_o(frc0), .start_at_sync_o(sas0)
  );

  pwm_align_ctrl #(.N_CH(N_CH), .CNT_W(CNT_W), .ASYNC_SYNC(1'b1)) u1 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .load_cfg(load_cfg), .ext_sync(ext_sync), .offs_cnt(cnt1),
    .align_o(al1), .chan_run(run1), .force_align_o(frc1), .start_at_sync_o(sas1)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Watch n samples; u0 strobe expected at sample k0 and u1 at k1 (0 = none).
  task automatic watch(input int n, input int k0, input int k1, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk(al0 == ((i == k0) ? {N_CH{1'b1}} : '0), {tag, " u0 strobe"}, int'(al0), (i == k0) ? 15 : 0);
      chk(al1 == ((i == k1) ? {N_CH{1'b1}} : '0), {tag, " u1 strobe"}, int'(al1), (i == k1) ? 15 : 0);
      if (i == k0) chk(cnt0 == 0, {tag, " R7 counter cleared"}, int'(cnt0), 0);
      if (k0 != 0 && i == k0 + 1) chk(cnt0 == 1, {tag, " R7 counter step"}, int'(cnt0), 1);
    end
  endtask

  task automatic drop_ext();
    @(negedge clk); ext_sync = 1'b0;
  endtask

  task automatic raise_ext();
    @(negedge clk); ext_sync = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk); load_cfg = 1'b1;
    @(negedge clk); load_cfg = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(run0 == 0, "R1 chan_run", run0, 0);
    chk(cnt0 == 0, "R1 counter", int'(cnt0), 0);
    chk(al0 == 0, "R1 strobe", int'(al0), 0);
    chk(frc0 == 0, "R1 force flag", frc0, 0);
    chk(sas0 == 1, "R1 start flag", sas0, 1);
  endtask

  task automatic t_hold();
    pulse_load();
    watch(4, 0, 0, "R2 load while held");
    ext_sync = 1'b1;
    raise_ext();
    pulse_load();
    drop_ext();
    watch(5, 0, 0, "R2 edges while held");
    chk(cnt0 == 0, "R2 counter held", int'(cnt0), 0);
    write_ctl(4'b1000);
    chk(run0 == 1, "R2 released", run0, 1);
    chk(cnt0 == 0, "R2 counter at release", int'(cnt0), 0);
    @(negedge clk);
    chk(cnt0 == 1, "R2 counter after release", int'(cnt0), 1);
  endtask

  task automatic t_unarmed();
    logic [CNT_W-1:0] prev;
    raise_ext();
    drop_ext();
    prev = cnt0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(al0 == 0 && al1 == 0, "R4 unarmed edge ignored", int'(al0), 0);
      chk(cnt0 == prev + 1'b1, "R4 counter runs", int'(cnt0), int'(prev + 1'b1));
      prev = cnt0;
    end
  endtask

  task automatic t_armed();
    raise_ext();
    pulse_load();
    watch(4, 0, 0, "R5 arm gives no strobe");
    drop_ext();
    watch(6, 2, 4, "R5 R11 armed fire");
    raise_ext();
    drop_ext();
    watch(6, 0, 0, "R5 arm consumed");
  endtask

  task automatic t_load_direct();
    pulse_load();
    watch(5, 2, 2, "R6 load with sync low");
  endtask

  task automatic t_ext_mode();
    write_ctl(4'b1010);
    raise_ext();
    drop_ext();
    watch(6, 2, 4, "R3 first sync edge");
    raise_ext();
    drop_ext();
    watch(6, 2, 4, "R3 second sync edge");
    raise_ext();
    pulse_load();
    watch(4, 2, 2, "R6 load in sync mode");
  endtask

  task automatic t_saturate();
    repeat (300) @(negedge clk);
    chk(cnt0 == TOP, "R8 saturated", int'(cnt0), int'(TOP));
    @(negedge clk);
    chk(cnt0 == TOP, "R8 stays saturated", int'(cnt0), int'(TOP));
    chk(al0 == 0, "R9 no strobe at top", int'(al0), 0);
  endtask

  task automatic t_flags();
    write_ctl(4'b0110);
    chk(frc0 == 1, "R10 force flag", frc0, 1);
    chk(sas0 == 0, "R10 start flag", sas0, 0);
    write_ctl(4'b0001);
    chk(run0 == 0, "R10 hold again", run0, 0);
    @(negedge clk);
    chk(cnt0 == 0, "R2 counter cleared on hold", int'(cnt0), 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    fork
      begin
        t_reset();
        t_hold();
        t_unarmed();
        t_armed();
        t_load_direct();
        t_ext_mode();
        t_saturate();
        t_flags();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule